// File: doc/BRIEF.md
# CAN Bit Timing Segment Sequencer

This block divides every CAN bit into time quanta and walks them through four segments in order: a single-quantum sync segment, a propagation segment, phase segment one and phase segment two. It advances only on a time-quantum tick supplied by an external prescaler. At the last quantum of phase segment one it captures the bus level and pulses a sample strobe. At the last quantum of phase segment two it pulses a bit-start strobe, and the next quantum is the sync segment of the following bit.

The segment lengths and the resynchronization jump width are programmed at the inputs as plain quantum counts. A falling bus edge (recessive 1 to dominant 0) seen outside the sync segment moves the bit's phase. An edge that arrives late, in propagation or phase segment one, lengthens phase segment one. An edge that arrives early, in phase segment two, shortens phase segment two. In both cases the adjustment is capped by the jump width, and only one adjustment is made per bit. An illegal setting raises an error flag and parks the sequencer in the sync segment until the setting is corrected.

Top module: `can_bit_sequencer`

## Requirements
- R1: After reset, `sample_stb`, `bit_start`, `sample_bit` and `cfg_err` are 0 and the sequencer is in the sync segment. With a legal setting and a tick every clock, the first `bit_start` is seen after the N-th tick, where N = 1 + prop + ph1 + ph2.
- R2: When no falling edge is present, consecutive `bit_start` pulses are N ticks apart. Each setting field carries its quantum count as a plain binary value.
- R3: `sample_stb` pulses on the tick that ends phase segment one. This is 1 + prop + ph1 ticks after a nominal `bit_start`. It never pulses in the same cycle as `bit_start`.
- R4: `sample_bit` takes the level of `rx_in` on the tick that raises `sample_stb` and holds it until the next sample.
- R5: `cfg_err` goes to 1 one clock after any of these holds: prop outside 1..8, ph1 or ph2 outside 2..8, sjw outside 1..4, ph1 < ph2, ph2 < sjw, or 1+prop+ph1+ph2 outside 8..25. It clears one clock after the setting becomes legal.
- R6: While `cfg_err` is 1, no strobe is produced and the sequencer is held in the sync segment. After a legal setting returns, the first `bit_start` follows after N ticks.
- R7: A falling edge in the propagation quantum or phase-one quantum at distance e after the sync segment lengthens phase segment one by min(e, sjw). Distance e counts the edge's own quantum, so the first propagation quantum has e = 1.
- R8: A falling edge in phase segment two with r quanta still remaining after its own quantum shortens phase segment two by min(r, sjw). If r ≤ sjw, the bit ends on that quantum. An edge in the last quantum (r = 0) changes nothing.
- R9: A falling edge in the sync segment, and any rising edge, leave the timing unchanged.
- R10: Only the first qualifying falling edge in a bit adjusts its timing. Later edges in the same bit are ignored.
- R11: The sequencer advances only on ticks where `tq_tick` is 1. With no ticks, no strobe occurs, and with one tick every k clocks all intervals scale by k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tq_tick | input | 1 | One-clock pulse per time quantum |
| cfg_prop | input | 4 | Propagation segment length in quanta |
| cfg_ph1 | input | 4 | Phase segment one length in quanta |
| cfg_ph2 | input | 4 | Phase segment two length in quanta |
| cfg_sjw | input | 3 | Resynchronization jump width in quanta |
| rx_in | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| sample_stb | output | 1 | Pulse when the bus is sampled |
| sample_bit | output | 1 | Bus level captured at the last sample |
| bit_start | output | 1 | Pulse at the end of a bit, before its successor's sync quantum |
| cfg_err | output | 1 | Setting breaks a range or ordering rule |

## Verification
Two functions can land on the same tick. A resynchronization decision can fall on the tick that would otherwise raise the sample strobe, when the falling edge sits in the last quantum of phase segment one. An early edge in phase segment two can also decide shortening and end the bit in one step. The bench places edges on exactly those quanta by counting clocks from a `bit_start`. It judges the result by the interval from that `bit_start` to the next sample and to the next bit start. For example, an edge in the final phase-one quantum must push the sample strobe out by the jump width rather than let it fire on time.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/can_bt_cfg_check.sv
module can_bt_cfg_check #(
  parameter int LEN_W    = 4,
  parameter int SJW_W    = 3,
  parameter int PROP_MIN = 1,
  parameter int PROP_MAX = 8,
  parameter int PH_MIN   = 2,
  parameter int PH_MAX   = 8,
  parameter int SJW_MIN  = 1,
  parameter int SJW_MAX  = 4,
  parameter int BIT_MIN  = 8,
  parameter int BIT_MAX  = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] prop,
  input  logic [LEN_W-1:0] ph1,
  input  logic [LEN_W-1:0] ph2,
  input  logic [SJW_W-1:0] sjw,
  output logic             bad,
  output logic             err_q
);
  localparam int TW = LEN_W + 2;
  localparam logic [LEN_W-1:0] P_LO = LEN_W'(PROP_MIN);
  localparam logic [LEN_W-1:0] P_HI = LEN_W'(PROP_MAX);
  localparam logic [LEN_W-1:0] H_LO = LEN_W'(PH_MIN);
  localparam logic [LEN_W-1:0] H_HI = LEN_W'(PH_MAX);
  localparam logic [SJW_W-1:0] J_LO = SJW_W'(SJW_MIN);
  localparam logic [SJW_W-1:0] J_HI = SJW_W'(SJW_MAX);
  localparam logic [TW-1:0]    T_LO = TW'(BIT_MIN);
  localparam logic [TW-1:0]    T_HI = TW'(BIT_MAX);

  logic [TW-1:0] total;
  logic          range_bad;
  logic          order_bad;
  logic          total_bad;

  always_comb begin
    total     = TW'(1) + TW'(prop) + TW'(ph1) + TW'(ph2);
    range_bad = (prop < P_LO) || (prop > P_HI) ||
                (ph1 < H_LO)  || (ph1 > H_HI)  ||
                (ph2 < H_LO)  || (ph2 > H_HI)  ||
                (sjw < J_LO)  || (sjw > J_HI);
    order_bad = (ph1 < ph2) || (ph2 < LEN_W'(sjw));
    total_bad = (total < T_LO) || (total > T_HI);
    bad       = range_bad || order_bad || total_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= bad;
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst,
  input  logic tq_tick,
  input  logic rx_in,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst)          prev_q <= 1'b1;
    else if (tq_tick) prev_q <= rx_in;
  end

  assign fall = tq_tick && prev_q && !rx_in;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_tick,
  input  logic             hold,
  input  logic [LEN_W-1:0] prop,
  input  logic [LEN_W-1:0] ph1,
  input  logic [LEN_W-1:0] ph2,
  input  logic [SJW_W-1:0] sjw,
  input  logic             rx_in,
  input  logic             fall,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);
  localparam int CW = LEN_W + 2;

  seg_e             seg_q;
  logic [LEN_W-1:0] cnt_q;
  logic [SJW_W-1:0] ext_q;
  logic [SJW_W-1:0] shr_q;
  logic             done_q;

  logic [CW-1:0]    cnt_inc;
  logic [CW-1:0]    late_err;
  logic [CW-1:0]    rem;
  logic [CW-1:0]    sjw_x;
  logic [CW-1:0]    ext_amt;
  logic [CW-1:0]    shr_amt;
  logic             apply;
  logic [SJW_W-1:0] ext_n;
  logic [SJW_W-1:0] shr_n;
  logic             prop_end;
  logic             ph1_end;
  logic             ph2_end;

  always_comb begin
    cnt_inc  = CW'(cnt_q) + CW'(1);
    sjw_x    = CW'(sjw);
    late_err = (seg_q == SEG_PH1) ? CW'(prop) + cnt_inc : cnt_inc;
    rem      = (cnt_inc >= CW'(ph2)) ? '0 : CW'(ph2) - cnt_inc;
    ext_amt  = (late_err < sjw_x) ? late_err : sjw_x;
    shr_amt  = (rem < sjw_x) ? rem : sjw_x;
    apply    = fall && !done_q && !hold &&
               ((seg_q == SEG_PROP) || (seg_q == SEG_PH1) ||
                ((seg_q == SEG_PH2) && (rem != '0)));
    ext_n    = (apply && (seg_q != SEG_PH2)) ? SJW_W'(ext_amt) : ext_q;
    shr_n    = (apply && (seg_q == SEG_PH2)) ? SJW_W'(shr_amt) : shr_q;
    prop_end = cnt_inc >= CW'(prop);
    ph1_end  = cnt_inc >= CW'(ph1) + CW'(ext_n);
    ph2_end  = cnt_inc + CW'(shr_n) >= CW'(ph2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q      <= SEG_SYNC;
      cnt_q      <= '0;
      ext_q      <= '0;
      shr_q      <= '0;
      done_q     <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b0;
      bit_start  <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      bit_start  <= 1'b0;
      if (tq_tick) begin
        if (hold) begin
          seg_q  <= SEG_SYNC;
          cnt_q  <= '0;
          ext_q  <= '0;
          shr_q  <= '0;
          done_q <= 1'b0;
        end else begin
          unique case (seg_q)
            SEG_SYNC: begin
              seg_q  <= SEG_PROP;
              cnt_q  <= '0;
              ext_q  <= '0;
              shr_q  <= '0;
              done_q <= 1'b0;
            end
            SEG_PROP: begin
              ext_q  <= ext_n;
              done_q <= done_q || apply;
              if (prop_end) begin
                seg_q <= SEG_PH1;
                cnt_q <= '0;
              end else begin
                cnt_q <= cnt_q + LEN_W'(1);
              end
            end
            SEG_PH1: begin
              ext_q  <= ext_n;
              done_q <= done_q || apply;
              if (ph1_end) begin
                seg_q      <= SEG_PH2;
                cnt_q      <= '0;
                sample_stb <= 1'b1;
                sample_bit <= rx_in;
              end else begin
                cnt_q <= cnt_q + LEN_W'(1);
              end
            end
            SEG_PH2: begin
              shr_q  <= shr_n;
              done_q <= done_q || apply;
              if (ph2_end) begin
                seg_q     <= SEG_SYNC;
                cnt_q     <= '0;
                bit_start <= 1'b1;
              end else begin
                cnt_q <= cnt_q + LEN_W'(1);
              end
            end
            default: seg_q <= SEG_SYNC;
          endcase
        end
      end
    end
  end

  // R3
  samp_single_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_start |=> !bit_start);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> !bit_start);

  // R11
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb || bit_start) |-> $past(tq_tick));

  // R11
  hold_still_chk: assert property (@(posedge clk) disable iff (rst)
    !tq_tick |=> ($stable(seg_q) && $stable(cnt_q)));

  // R6
  park_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && tq_tick) |=> (seg_q == SEG_SYNC));
endmodule

// File: rtl/can_bit_sequencer.sv
module can_bit_sequencer #(
  parameter int LEN_W    = 4,
  parameter int SJW_W    = 3,
  parameter int PROP_MIN = 1,
  parameter int PROP_MAX = 8,
  parameter int PH_MIN   = 2,
  parameter int PH_MAX   = 8,
  parameter int SJW_MIN  = 1,
  parameter int SJW_MAX  = 4,
  parameter int BIT_MIN  = 8,
  parameter int BIT_MAX  = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_tick,
  input  logic [LEN_W-1:0] cfg_prop,
  input  logic [LEN_W-1:0] cfg_ph1,
  input  logic [LEN_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             rx_in,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start,
  output logic             cfg_err
);
  logic bad;
  logic fall;

  can_bt_cfg_check #(
    .LEN_W(LEN_W), .SJW_W(SJW_W),
    .PROP_MIN(PROP_MIN), .PROP_MAX(PROP_MAX),
    .PH_MIN(PH_MIN), .PH_MAX(PH_MAX),
    .SJW_MIN(SJW_MIN), .SJW_MAX(SJW_MAX),
    .BIT_MIN(BIT_MIN), .BIT_MAX(BIT_MAX)
  ) u_cfg (
    .clk  (clk),
    .rst  (rst),
    .prop (cfg_prop),
    .ph1  (cfg_ph1),
    .ph2  (cfg_ph2),
    .sjw  (cfg_sjw),
    .bad  (bad),
    .err_q(cfg_err)
  );

  can_bt_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .tq_tick(tq_tick),
    .rx_in  (rx_in),
    .fall   (fall)
  );

  can_bt_seq #(
    .LEN_W(LEN_W), .SJW_W(SJW_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tq_tick   (tq_tick),
    .hold      (bad),
    .prop      (cfg_prop),
    .ph1       (cfg_ph1),
    .ph2       (cfg_ph2),
    .sjw       (cfg_sjw),
    .rx_in     (rx_in),
    .fall      (fall),
    .sample_stb(sample_stb),
    .sample_bit(sample_bit),
    .bit_start (bit_start)
  );

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!sample_stb && !bit_start));

  // R5
  err_settles_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(cfg_prop) && $stable(cfg_ph1) && $stable(cfg_ph2) &&
     $stable(cfg_sjw) && !$past(rst)) |=> $stable(cfg_err));
endmodule

// File: tb/can_bit_sequencer_tb.sv
module can_bit_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tq_tick = 1'b1;
  logic [3:0] cfg_prop = 4'd2;
  logic [3:0] cfg_ph1  = 4'd3;
  logic [3:0] cfg_ph2  = 4'd2;
  logic [2:0] cfg_sjw  = 3'd1;
  logic       rx_in = 1'b1;
  logic       sample_stb, sample_bit, bit_start, cfg_err;

  int chk_n = 0;
  int err_n = 0;
  int tick_div = 1;
  int tick_ctr = 0;
  logic tick_hold = 1'b0;

  always #5 clk = ~clk;

  can_bit_sequencer u_dut (
    .clk(clk), .rst(rst), .tq_tick(tq_tick),
    .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
    .rx_in(rx_in), .sample_stb(sample_stb), .sample_bit(sample_bit),
    .bit_start(bit_start), .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    if (tick_hold) begin
      tq_tick <= 1'b0;
    end else if (tick_ctr + 1 >= tick_div) begin
      tick_ctr <= 0;
      tq_tick  <= 1'b1;
    end else begin
      tick_ctr <= tick_ctr + 1;
      tq_tick  <= 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    chk_n++;
    if (act != exp) begin
      err_n++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", err_n, chk_n);
    $finish;
  endtask

  task automatic set_cfg(input int p, input int a, input int b, input int j);
    cfg_prop = 4'(p);
    cfg_ph1  = 4'(a);
    cfg_ph2  = 4'(b);
    cfg_sjw  = 3'(j);
  endtask

  task automatic restart(input int p, input int a, input int b, input int j);
    @(negedge clk);
    rst = 1'b1;
    rx_in = 1'b1;
    set_cfg(p, a, b, j);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sync_to_start();
    int n = 0;
    while (!bit_start && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Called at a negedge where bit_start is 1; edge drives at quantum index k.
  task automatic run_bit(input int fall_at, input int rise_at, input int fall2_at,
                         output int to_samp, output int to_next, output int sval);
    int n = 0;
    to_samp = -1;
    to_next = -1;
    sval = -1;
    forever begin
      if (n == fall_at)  rx_in = 1'b0;
      if (n == rise_at)  rx_in = 1'b1;
      if (n == fall2_at) rx_in = 1'b0;
      @(negedge clk);
      n++;
      if (sample_stb && to_samp < 0) begin
        to_samp = n;
        sval = int'(sample_bit);
      end
      if (bit_start || n > 400) begin
        to_next = n;
        break;
      end
    end
  endtask

  task automatic t_reset();
    int n = 0;
    restart(2, 3, 2, 1);
    chk("R1 sample_stb at reset", int'(sample_stb), 0);
    chk("R1 bit_start at reset", int'(bit_start), 0);
    chk("R1 sample_bit at reset", int'(sample_bit), 0);
    chk("R1 cfg_err at reset", int'(cfg_err), 0);
    while (!bit_start && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R1 first bit_start tick", n, 8);
  endtask

  task automatic t_nominal(input int p, input int a, input int b, input int j);
    int s, nx, v;
    restart(p, a, b, j);
    sync_to_start();
    for (int i = 0; i < 2; i++) begin
      run_bit(-1, -1, -1, s, nx, v);
      chk("R3 start to sample", s, 1 + p + a);
      chk("R2 bit length", nx, 1 + p + a + b);
    end
  endtask

  task automatic t_sample();
    int s, nx, v;
    restart(2, 4, 3, 2);
    sync_to_start();
    run_bit(-1, -1, -1, s, nx, v);
    run_bit(0, -1, -1, s, nx, v);
    chk("R4 sampled dominant", v, 0);
    chk("R9 sync-edge sample timing", s, 7);
    chk("R9 sync-edge bit length", nx, 10);
    chk("R4 sample_bit held", int'(sample_bit), 0);
    run_bit(-1, 3, -1, s, nx, v);
    chk("R4 sampled recessive", v, 1);
    chk("R9 rising-edge bit length", nx, 10);
  endtask

  task automatic t_lengthen(input int k, input int exp_s, input int exp_n);
    int s, nx, v;
    restart(2, 4, 3, 2);
    sync_to_start();
    run_bit(-1, -1, -1, s, nx, v);
    run_bit(k, -1, -1, s, nx, v);
    chk("R7 lengthened sample", s, exp_s);
    chk("R7 lengthened bit", nx, exp_n);
    run_bit(-1, 0, -1, s, nx, v);
    chk("R7 next bit nominal", nx, 10);
  endtask

  task automatic t_shorten(input int j, input int k, input int exp_n);
    int s, nx, v;
    restart(2, 4, 3, j);
    sync_to_start();
    run_bit(-1, -1, -1, s, nx, v);
    run_bit(k, -1, -1, s, nx, v);
    chk("R8 sample unmoved", s, 7);
    chk("R8 shortened bit", nx, exp_n);
    run_bit(-1, 0, -1, s, nx, v);
    chk("R8 following sample", s, 7);
    chk("R8 following bit", nx, 10);
  endtask

  task automatic t_once();
    int s, nx, v;
    restart(2, 4, 3, 2);
    sync_to_start();
    run_bit(-1, -1, -1, s, nx, v);
    run_bit(1, 2, 4, s, nx, v);
    chk("R10 second edge ignored sample", s, 8);
    chk("R10 second edge ignored bit", nx, 11);
  endtask

  task automatic t_cfg_err();
    int bp[9] = '{0, 9, 2, 2, 2, 2, 2, 2, 1};
    int ba[9] = '{4, 4, 1, 9, 4, 4, 3, 4, 2};
    int bb[9] = '{3, 3, 3, 3, 3, 3, 4, 2, 2};
    int bj[9] = '{2, 2, 2, 2, 0, 5, 2, 3, 1};
    int strobes, n;
    restart(2, 4, 3, 2);
    sync_to_start();
    for (int c = 0; c < 9; c++) begin
      @(negedge clk);
      set_cfg(bp[c], ba[c], bb[c], bj[c]);
      @(negedge clk);
      chk("R5 cfg_err raised", int'(cfg_err), 1);
      strobes = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (sample_stb || bit_start) strobes++;
      end
      chk("R6 no strobes in error", strobes, 0);
      set_cfg(2, 4, 3, 2);
      n = 0;
      @(negedge clk);
      n++;
      chk("R5 cfg_err cleared", int'(cfg_err), 0);
      while (!bit_start && n < 100) begin
        @(negedge clk);
        n++;
      end
      chk("R6 restart from sync", n, 10);
    end
    @(negedge clk);
    set_cfg(1, 3, 3, 3);
    repeat (2) @(negedge clk);
    chk("R5 minimum total legal", int'(cfg_err), 0);
    set_cfg(8, 8, 8, 4);
    repeat (2) @(negedge clk);
    chk("R5 maximum total legal", int'(cfg_err), 0);
  endtask

  task automatic t_tick();
    int s, nx, v, strobes;
    restart(2, 4, 3, 2);
    tick_div = 3;
    sync_to_start();
    run_bit(-1, -1, -1, s, nx, v);
    chk("R11 scaled sample", s, 21);
    chk("R11 scaled bit", nx, 30);
    tick_hold = 1'b1;
    strobes = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sample_stb || bit_start) strobes++;
    end
    chk("R11 no strobes without ticks", strobes, 0);
    tick_hold = 1'b0;
    tick_div = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err_n++;
    chk_n++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    t_reset();
    t_nominal(2, 3, 2, 1);
    t_nominal(8, 8, 8, 4);
    t_nominal(1, 8, 3, 3);
    t_sample();
    t_lengthen(1, 8, 11);
    t_lengthen(4, 9, 12);
    t_lengthen(6, 9, 12);
    t_shorten(2, 7, 8);
    t_shorten(2, 8, 9);
    t_shorten(2, 9, 10);
    t_shorten(1, 7, 9);
    t_once();
    t_cfg_err();
    t_tick();
    summary();
  end
endmodule